// File: doc/BRIEF.md
# I2S Audio Receive Channel

This block turns an I2S serial stream into parallel audio samples and offers each finished sample on a one-cycle push port. The port feeds a receive FIFO that sits outside the block. A sample can be 8, 16 or 32 bits wide, and the channel runs in stereo or mono.

The channel works in one of two roles. As bus master it makes its own bit clock by toggling `sck_out` on each `bit_en` pulse, and it makes word select from a 9-bit half-period counter. As slave it takes `sck_in` and `ws_in` from the bus and brings them into the system clock domain, with `sd_in` kept in step with them. The choice of role belongs to the receive channel alone.

A stop control keeps samples out of the FIFO while the serial timing keeps running. When the FIFO is full, a finished sample is discarded and a sticky overrun flag is raised. The flag clears only on the system reset or the channel reset.

Top module: `i2s_rx_chan`

## Requirements
- R1: `cfg_width` picks the sample size: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 gives 32 bits. Each sample leaves the block right-aligned in `push_data`, with the bits above the sample size at zero.
- R2: Data bits are taken on rising bit-clock edges with the MSB first. The MSB is the bit on the second rising edge after word select changes. Bits that arrive after the chosen width, up to the next change of word select, are discarded.
- R3: In stereo mode (`cfg_mono`=0) every finished half-frame is pushed. Word select low marks the left sample and word select high marks the right sample, so the push order follows the bus: left, then right.
- R4: In mono mode (`cfg_mono`=1) only half-frames received with word select low are pushed. Half-frames with word select high never reach the push port.
- R5: When `cfg_master`=1, `sck_out` toggles on each `bit_en` pulse. `ws_out` changes only with a falling edge of `sck_out`, and it toggles every `cfg_ws_half`+1 bit-clock periods.
- R6: When `cfg_master`=0, `sck_in`, `ws_in` and `sd_in` each pass through a two-stage synchronizer before use. The system clock must run at least four times faster than `sck_in`. In this mode `sck_out` and `ws_out` stay low.
- R7: While `cfg_stop`=1, no sample is pushed and the overrun flag does not change. The master bit clock and word select keep running during this time.
- R8: If a sample finishes while `fifo_full`=1, it is not pushed and `overrun` goes high. `overrun` then stays high until reset.
- R9: `cfg_reset` clears the deserializer, the pending push, `overrun` and the master counters, so `sck_out` and `ws_out` both return to 0.
- R10: While `rst` is high and after it falls, `push_valid`, `push_data`, `overrun`, `sck_out` and `ws_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate the bit clock and word select; 0: take them from the bus |
| cfg_stop | input | 1 | Blocks pushes into the FIFO |
| cfg_reset | input | 1 | Channel reset |
| cfg_mono | input | 1 | 1: store only the left (word select low) sample |
| cfg_width | input | 2 | Sample size select (0: 8, 1: 16, 2 or 3: 32 bits) |
| cfg_ws_half | input | 9 | Word select half-period in bit-clock periods, minus one |
| bit_en | input | 1 | Master-mode bit clock toggle enable |
| sck_in | input | 1 | Slave-mode bus bit clock |
| ws_in | input | 1 | Slave-mode bus word select |
| sd_in | input | 1 | Serial data |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| sck_out | output | 1 | Master-mode bit clock |
| ws_out | output | 1 | Master-mode word select |
| push_valid | output | 1 | One-cycle FIFO write strobe |
| push_data | output | 32 | Sample being pushed, right-aligned |
| overrun | output | 1 | Sticky flag: a sample was dropped on a full FIFO |

## Verification
The assertions assume `rst` is high at the first clock edge. They also assume the configuration inputs stay constant while a stream is in progress and that `cfg_reset` follows any change of role. In slave mode the bench changes `ws_in` and `sd_in` only while `sck_in` is low, and it holds each bit-clock level for four system cycles, which gives eight cycles per bit. In master mode it changes data only right after a falling edge of `sck_out`, and it spaces `bit_en` pulses four cycles apart. Each stream opens with a lead-in slot that has word select high and closes with a trailing slot, so the first and last samples of the stream are bounded by word select transitions.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  typedef enum logic [1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2
  } wsel_e;

  // sample size in bits for a width select code
  function automatic logic [5:0] width_bits(input logic [1:0] sel);
    case (sel)
      WSEL_8:  width_bits = 6'd8;
      WSEL_16: width_bits = 6'd16;
      default: width_bits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic rise,
  output logic ws,
  output logic sd
);
  // one extra bit-clock stage for edge detection
  logic [STAGES:0]   sck_p;
  logic [STAGES-1:0] ws_p;
  logic [STAGES-1:0] sd_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      ws_p  <= '0;
      sd_p  <= '0;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sck_in};
      ws_p  <= {ws_p[STAGES-2:0], ws_in};
      sd_p  <= {sd_p[STAGES-2:0], sd_in};
    end
  end

  assign rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign ws   = ws_p[STAGES-1];
  assign sd   = sd_p[STAGES-1];
endmodule

// File: rtl/i2s_rx_wsgen.sv
module i2s_rx_wsgen #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_en,
  input  logic [CNT_W-1:0] half_len,
  output logic             sck_o,
  output logic             ws_o,
  output logic             rise_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sck_o  <= 1'b0;
      ws_o   <= 1'b0;
      rise_o <= 1'b0;
      cnt    <= '0;
    end else begin
      rise_o <= bit_en & ~sck_o;
      if (bit_en) begin
        sck_o <= ~sck_o;
        if (sck_o) begin
          // falling bit-clock edge: advance the frame counter
          if (cnt == half_len) begin
            cnt  <= '0;
            ws_o <= ~ws_o;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R5: word select moves only together with a falling bit clock
  a_r5_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ws_o) && !$past(clr)) |-> $fell(sck_o));
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rise,
  input  logic              ws,
  input  logic              sd,
  input  logic [CNT_W-1:0]  wbits,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              chan
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              ws_prev;
  logic              take;
  logic [DATA_W-1:0] sh_next;

  assign take    = rise && (cnt < wbits);
  assign sh_next = {sh[DATA_W-2:0], sd};
  assign done    = take && ((cnt + CNT_W'(1)) == wbits);
  assign word    = sh_next;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh      <= '0;
      cnt     <= IDLE;
      chan    <= 1'b0;
      ws_prev <= 1'b0;
    end else if (rise) begin
      ws_prev <= ws;
      if (ws != ws_prev) begin
        // this edge still carries the last bit of the old half-frame
        sh   <= '0;
        cnt  <= '0;
        chan <= ws;
      end else if (take) begin
        sh  <= sh_next;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2: the bit counter never runs past the idle mark
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= IDLE);
endmodule

// File: rtl/i2s_rx_chan.sv
module i2s_rx_chan
  import i2s_rx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int WS_CNT_W    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_master,
  input  logic                cfg_stop,
  input  logic                cfg_reset,
  input  logic                cfg_mono,
  input  logic [1:0]          cfg_width,
  input  logic [WS_CNT_W-1:0] cfg_ws_half,
  input  logic                bit_en,
  input  logic                sck_in,
  input  logic                ws_in,
  input  logic                sd_in,
  input  logic                fifo_full,
  output logic                sck_out,
  output logic                ws_out,
  output logic                push_valid,
  output logic [DATA_W-1:0]   push_data,
  output logic                overrun
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic s_rise, s_ws, s_sd;
  logic m_rise;
  logic rise, ws, sd;
  logic done, chan, accept;
  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  wbits;

  i2s_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .rise(s_rise), .ws(s_ws), .sd(s_sd)
  );

  i2s_rx_wsgen #(.CNT_W(WS_CNT_W)) u_wsgen (
    .clk(clk), .rst(rst), .clr(cfg_reset | ~cfg_master),
    .bit_en(bit_en), .half_len(cfg_ws_half),
    .sck_o(sck_out), .ws_o(ws_out), .rise_o(m_rise)
  );

  assign rise  = cfg_master ? m_rise : s_rise;
  assign ws    = cfg_master ? ws_out : s_ws;
  assign sd    = cfg_master ? sd_in  : s_sd;
  assign wbits = CNT_W'(width_bits(cfg_width));

  i2s_rx_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst(rst), .clr(cfg_reset),
    .rise(rise), .ws(ws), .sd(sd), .wbits(wbits),
    .done(done), .word(word), .chan(chan)
  );

  assign accept = done && !(cfg_mono && chan) && !cfg_stop;

  always_ff @(posedge clk) begin
    if (rst || cfg_reset) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      overrun    <= 1'b0;
    end else begin
      push_valid <= accept && !fifo_full;
      if (accept && !fifo_full) push_data <= word;
      if (accept && fifo_full)  overrun   <= 1'b1;
    end
  end

  // R7: nothing reaches the FIFO while stopped
  a_r7_stop_blocks_push: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> !$past(cfg_stop));
  // R8: a full FIFO is never written
  a_r8_full_no_push: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> !$past(fifo_full));
  // R8: overrun holds until a reset
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !cfg_reset) |=> overrun);
endmodule

// File: tb/tb_i2s_rx_chan.sv
module tb_i2s_rx_chan;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_master = 1'b0, cfg_stop = 1'b0, cfg_reset = 1'b0, cfg_mono = 1'b0;
  logic [1:0] cfg_width = 2'd2;
  logic [8:0] cfg_ws_half = 9'd15;
  logic bit_en = 1'b0;
  logic sck_in = 1'b0, ws_in = 1'b0, sd_s = 1'b0, sd_m = 1'b0;
  logic sd_in;
  logic fifo_full = 1'b0;
  logic sck_out, ws_out, push_valid, overrun;
  logic [31:0] push_data;

  assign sd_in = cfg_master ? sd_m : sd_s;

  i2s_rx_chan dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_stop(cfg_stop),
    .cfg_reset(cfg_reset), .cfg_mono(cfg_mono), .cfg_width(cfg_width),
    .cfg_ws_half(cfg_ws_half), .bit_en(bit_en), .sck_in(sck_in),
    .ws_in(ws_in), .sd_in(sd_in), .fifo_full(fifo_full),
    .sck_out(sck_out), .ws_out(ws_out), .push_valid(push_valid),
    .push_data(push_data), .overrun(overrun)
  );

  int checks = 0, errors = 0;
  logic [31:0] cap [0:63];
  int ncap = 0;
  logic [31:0] txl [0:1];
  logic [31:0] txr [0:1];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // capture pushed words
  always @(negedge clk) begin
    if (push_valid && ncap < 64) begin
      cap[ncap] = push_data;
      ncap++;
    end
  end

  // master-mode bit enable and data driver
  int bcnt = 0;
  bit mdrive = 0;
  logic sck_prev = 1'b0, ws_last = 1'b0, mprev = 1'b0;
  int midx = 0, rcnt = 0, last_period = 0, ws_toggles = 0;
  logic [7:0] ml = 8'hA5, mr = 8'h3C;
  always @(negedge clk) begin
    bcnt = (bcnt + 1) % 4;
    bit_en = (bcnt == 0);
    if (mdrive) begin
      if (!sck_prev && sck_out) rcnt++;
      if (sck_prev && !sck_out) begin
        logic [7:0] w;
        logic b;
        if (ws_out != ws_last) begin
          ws_last = ws_out;
          midx = 0;
          last_period = rcnt;
          rcnt = 0;
          ws_toggles++;
        end
        w = ws_out ? mr : ml;
        b = (midx < 8) ? w[7-midx] : 1'b0;
        sd_m = mprev;
        mprev = b;
        midx++;
      end
    end
    sck_prev = sck_out;
  end

  task automatic chan_reset();
    @(negedge clk) cfg_reset = 1'b1;
    @(negedge clk) cfg_reset = 1'b0;
    @(negedge clk);
    ncap = 0;
  endtask

  task automatic slot(input logic w, input logic d);
    @(negedge clk);
    sck_in = 1'b0; ws_in = w; sd_s = d;
    repeat (4) @(negedge clk);
    sck_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // lead-in slot, nfr stereo frames, trailing slot
  task automatic stream(input int nfr, input int slots, input int wb);
    logic prev;
    prev = 1'b0;
    slot(1'b1, 1'b0);
    for (int f = 0; f < nfr; f++) begin
      for (int h = 0; h < 2; h++) begin
        for (int j = 0; j < slots; j++) begin
          logic [31:0] w;
          logic b;
          w = h ? txr[f] : txl[f];
          b = (j < wb) ? w[wb-1-j] : 1'b0;
          slot(h[0], prev);
          prev = b;
        end
      end
    end
    slot(1'b0, prev);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(push_valid == 0, "R10 push_valid", 32'(push_valid), 0);
    chk(overrun == 0, "R10 overrun", 32'(overrun), 0);
    chk(sck_out == 0 && ws_out == 0, "R10 sck/ws out", {30'd0, sck_out, ws_out}, 0);
    chk(push_data == 0, "R10 push_data", push_data, 0);
  endtask

  task automatic t_stereo32();
    cfg_master = 0; cfg_mono = 0; cfg_width = 2'd2;
    txl[0] = 32'h8123_4567; txr[0] = 32'h89AB_CDEF;
    txl[1] = 32'h0F1E_2D3C; txr[1] = 32'hF00D_0001;
    chan_reset();
    stream(2, 32, 32);
    chk(ncap == 4, "R3 stereo word count", 32'(ncap), 4);
    chk(cap[0] == txl[0], "R1 R3 R6 left0 32b", cap[0], txl[0]);
    chk(cap[1] == txr[0], "R3 right0 32b", cap[1], txr[0]);
    chk(cap[2] == txl[1], "R3 left1 32b", cap[2], txl[1]);
    chk(cap[3] == txr[1], "R3 right1 32b", cap[3], txr[1]);
    chk(sck_out == 0 && ws_out == 0, "R6 outputs low in slave", {30'd0, sck_out, ws_out}, 0);
  endtask

  task automatic t_stereo16();
    cfg_width = 2'd1;
    txl[0] = 32'h0000_BEEF; txr[0] = 32'h0000_8001;
    txl[1] = 32'h0000_1234; txr[1] = 32'h0000_FFFF;
    chan_reset();
    stream(2, 32, 16);
    chk(ncap == 4, "R2 16b count", 32'(ncap), 4);
    chk(cap[0] == txl[0], "R1 R2 left0 16b", cap[0], txl[0]);
    chk(cap[1] == txr[0], "R2 right0 16b", cap[1], txr[0]);
    chk(cap[3] == txr[1], "R1 right1 16b upper zero", cap[3], txr[1]);
  endtask

  task automatic t_mono8();
    cfg_width = 2'd0; cfg_mono = 1;
    txl[0] = 32'h0000_00C3; txr[0] = 32'h0000_0055;
    txl[1] = 32'h0000_0081; txr[1] = 32'h0000_007E;
    chan_reset();
    stream(2, 16, 8);
    chk(ncap == 2, "R4 mono count", 32'(ncap), 2);
    chk(cap[0] == txl[0], "R4 mono left0", cap[0], txl[0]);
    chk(cap[1] == txl[1], "R4 mono left1", cap[1], txl[1]);
    cfg_mono = 0;
  endtask

  task automatic t_overrun();
    cfg_width = 2'd0;
    txl[0] = 32'h11; txr[0] = 32'h22;
    chan_reset();
    fifo_full = 1;
    stream(1, 16, 8);
    chk(ncap == 0, "R8 no push when full", 32'(ncap), 0);
    chk(overrun == 1, "R8 overrun set", 32'(overrun), 1);
    fifo_full = 0;
    chan_reset();
    chk(overrun == 0, "R9 overrun cleared", 32'(overrun), 0);
    fifo_full = 1;
    stream(1, 16, 8);
    fifo_full = 0;
    txl[0] = 32'h33; txr[0] = 32'h44;
    stream(1, 16, 8);
    chk(overrun == 1, "R8 overrun sticky", 32'(overrun), 1);
    chk(ncap == 2 && cap[0] == 32'h33, "R8 pushes resume", cap[0], 32'h33);
  endtask

  task automatic t_stop_slave();
    chan_reset();
    cfg_stop = 1; fifo_full = 1;
    stream(1, 16, 8);
    chk(ncap == 0, "R7 stop no push", 32'(ncap), 0);
    chk(overrun == 0, "R7 stop no overrun", 32'(overrun), 0);
    cfg_stop = 0; fifo_full = 0;
  endtask

  task automatic t_master();
    cfg_master = 1; cfg_width = 2'd0; cfg_ws_half = 9'd15;
    chan_reset();
    ws_last = 0; mprev = 0; midx = 0; rcnt = 0; ws_toggles = 0;
    mdrive = 1;
    repeat (1400) @(negedge clk);
    mdrive = 0;
    chk(ncap >= 4, "R5 master count", 32'(ncap), 4);
    chk(cap[0] == 32'h3C, "R5 master right first", cap[0], 32'h3C);
    chk(cap[1] == 32'hA5, "R5 master left", cap[1], 32'hA5);
    chk(cap[3] == 32'hA5, "R5 master left again", cap[3], 32'hA5);
    chk(last_period == 16, "R5 ws half-period", 32'(last_period), 16);
  endtask

  task automatic t_master_stop();
    cfg_stop = 1;
    chan_reset();
    ws_last = 0; mprev = 0; midx = 0; rcnt = 0; ws_toggles = 0;
    mdrive = 1;
    repeat (600) @(negedge clk);
    mdrive = 0;
    chk(ncap == 0, "R7 master stop no push", 32'(ncap), 0);
    chk(ws_toggles >= 3, "R7 timing runs while stopped", 32'(ws_toggles), 3);
    cfg_stop = 0;
    @(negedge clk) cfg_reset = 1;
    @(negedge clk) cfg_reset = 0;
    chk(sck_out == 0 && ws_out == 0, "R9 master counters cleared", {30'd0, sck_out, ws_out}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_stereo32();
    t_stereo16();
    t_mono8();
    t_overrun();
    t_stop_slave();
    t_master();
    t_master_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule